// File: doc/BRIEF.md
# Eight-Source Priority Interrupt Unit

This block holds the pending-interrupt state of a 16-bit stack processor and decides, at each instruction boundary, which pending source the core enters next. Three external pins (non-maskable request, bus fault, general request) pass through a two-flop synchronizer and a rising-edge detector before they latch. Two internal pulses (arithmetic fault, software request) and the core's interrupt-raise command latch directly. Sources 0 to 3 are always serviceable. Sources 4 to 7 are gated by four enable bits that the core supplies from its flag register bits [7:4].

When the core signals an instruction boundary and the unit is idle, the unit captures the lowest-numbered serviceable pending source. It then presents that selection until the core acknowledges it. The selection comes with the vector fetch address, a push request with the one-hot word to push ahead of the return address, and the mask of flag-register bits the core must clear. The core performs the pushes and the vector fetch itself. It pulses the acknowledge once they are done, and the unit then retires the pending bit. The core drains pending sources by repeating this exchange at each boundary until nothing serviceable remains.

Top module: `intr_ctrl`

## Requirements
- R1: After synchronous reset the pending word reads 0x0001 (reset source pending) and no service is offered.
- R2: A rising edge on `nmi_pin`, `bus_pin` or `irq_pin` sets pending bit 1, 2 or 7 respectively. If the pin is low before clock edge k and high at edge k, the bit reads set after edge k+2. A level held high latches only once.
- R3: `arith_err` sets bit 4 and `sw_req` sets bit 5. Bit 4 latches only when `fr_enable[0]` is 1, bit 5 only when `fr_enable[1]` is 1, and bit 7 only when `fr_enable[3]` is 1. Otherwise the request is dropped.
- R4: `raise_en` ORs `raise_bits` into the pending word under the same enables as R3. Bits 3 and 6 never set, and `pend_out[15:8]` always reads 0.
- R5: At a clock edge where `boundary` is 1 and no service is open, the unit captures the lowest index n whose pending bit is set and for which either n<4 or `fr_enable[n-4]` is 1. A pending maskable bit whose enable is 0 is skipped and stays pending.
- R6: While a service is open, `svc_index` is n and `svc_vector` is 2*n.
- R7: For an open service with n≠0, `svc_push` is 1 and `svc_push_word` is 1<<n. The core pushes that word and then the return address.
- R8: For n=0, `svc_is_reset` is 1, `svc_push` is 0, `fr_clr_mask` is 0xFFFF, and the acknowledge clears the whole pending word.
- R9: `fr_clr_mask` is 1<<n for 4≤n≤7 and 0 for n in 1..3, which clears the entered source's enable in the flag register.
- R10: An open service holds its index until `svc_ack`. The acknowledge clears bit n, and `svc_valid` is 0 in the following cycle. A new request for the same bit in the acknowledge cycle survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Asynchronous non-maskable request pin |
| bus_pin | input | 1 | Asynchronous bus-fault pin |
| irq_pin | input | 1 | Asynchronous maskable request pin |
| arith_err | input | 1 | One-cycle arithmetic-fault pulse from the ALU |
| sw_req | input | 1 | One-cycle software-request pulse |
| raise_en | input | 1 | Interrupt-raise command strobe |
| raise_bits | input | 8 | Low byte of the raise command operand |
| fr_enable | input | 4 | Enables for sources 4..7 (flag bits [7:4]) |
| boundary | input | 1 | Core is at an instruction boundary |
| svc_ack | input | 1 | Core finished pushes and vector fetch |
| svc_valid | output | 1 | A service is open |
| svc_index | output | 3 | Index of the open service |
| svc_is_reset | output | 1 | Open service is the reset source |
| svc_push | output | 1 | Core must push the word and the return address |
| svc_push_word | output | 16 | One-hot word to push |
| svc_vector | output | 16 | Vector table address to fetch |
| fr_clr_mask | output | 16 | Flag-register bits to clear on entry |
| pend_out | output | 16 | Pending word |

## Verification
The acknowledge that retires a source can land in the same cycle as a fresh request for that same source, or for a lower-numbered one that will win the next boundary. The bench forces the first case directly by pulsing the software request together with the acknowledge of source 5 and checking that bit 5 is still pending afterwards. The random phase produces both cases at random against a cycle-accurate reference model that also tracks the synchronizer delay, and compares every output in every cycle.

// File: rtl/intr_pkg.sv
// Shared constants and types for the interrupt unit.
// Assumes eight sources with the maskable group in the upper half.
package intr_pkg;
    localparam int unsigned INTR_N    = 8;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned IDX_W     = $clog2(INTR_N);
    localparam int unsigned MASK_LO   = 4;
    localparam int unsigned EN_W      = INTR_N - MASK_LO;
    localparam int unsigned SYNC_LEN  = 2;

    localparam int unsigned SRC_RST   = 0;
    localparam int unsigned SRC_NMI   = 1;
    localparam int unsigned SRC_BUS   = 2;
    localparam int unsigned SRC_ARITH = 4;
    localparam int unsigned SRC_SW    = 5;
    localparam int unsigned SRC_IRQ   = 7;

    // Bits that can ever hold a pending request (3 and 6 are dead).
    localparam logic [INTR_N-1:0] LIVE_MASK = 8'hB7;

    typedef logic [INTR_N-1:0] pend_t;
    typedef enum logic { ST_IDLE, ST_BUSY } svc_state_e;
endpackage

// File: rtl/intr_edge_sync.sv
// Synchronizes N asynchronous pins through SYNC_LEN flops and emits a
// one-cycle pulse on each synchronized rising edge.
// Assumes pins stay at one level for at least one clock at a time.
module intr_edge_sync #(
    parameter int unsigned N        = 3,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise
);
    localparam int unsigned CHAIN_W = SYNC_LEN + 1;

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [CHAIN_W-1:0] chain;

        // Shift the pin through the synchronizer plus one history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[CHAIN_W-2:0], pin[g]};
        end

        assign rise[g] = chain[SYNC_LEN-1] & ~chain[SYNC_LEN];
    end
endmodule

// File: rtl/intr_pend_reg.sv
// Pending-interrupt word: clears first, then ORs new requests, so a request
// arriving in the clearing cycle is kept. Dead bits never hold a one.
// Assumes set_vec is already gated by the enables.
module intr_pend_reg
    import intr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pend_t set_vec,
    input  pend_t clr_vec,
    output pend_t pend
);
    // Update the pending word; reset leaves only the reset source pending.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= pend_t'(1 << SRC_RST);
        else        pend <= ((pend & ~clr_vec) | set_vec) & LIVE_MASK;
    end

    AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~LIVE_MASK) == '0); // R4
    AST_NEW_REQ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec != '0 |=> (pend & $past(set_vec & LIVE_MASK)) == $past(set_vec & LIVE_MASK)); // R10
endmodule

// File: rtl/intr_select.sv
// Combinational priority pick: lowest-numbered pending source that is
// either unmaskable or enabled. Assumes pend has dead bits at zero.
module intr_select
    import intr_pkg::*;
(
    input  pend_t            pend,
    input  logic [EN_W-1:0]  fr_enable,
    output logic             any,
    output logic [IDX_W-1:0] sel
);
    pend_t serviceable;
    assign serviceable = pend & {fr_enable, {MASK_LO{1'b1}}};
    assign any = |serviceable;

    // Scan downward so the lowest set index is the last assignment.
    always_comb begin
        sel = '0;
        for (int i = INTR_N - 1; i >= 0; i--) begin
            if (serviceable[i]) sel = IDX_W'(i);
        end
    end
endmodule

// File: rtl/intr_ctrl.sv
// Interrupt unit top: gathers requests, keeps the pending word, captures one
// source per boundary and holds it until the core acknowledges the entry.
// Assumes the core pulses svc_ack once, only after pushes and vector fetch.
module intr_ctrl
    import intr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         nmi_pin,
    input  logic         bus_pin,
    input  logic         irq_pin,
    input  logic         arith_err,
    input  logic         sw_req,
    input  logic         raise_en,
    input  logic [7:0]   raise_bits,
    input  logic [3:0]   fr_enable,
    input  logic         boundary,
    input  logic         svc_ack,
    output logic         svc_valid,
    output logic [2:0]   svc_index,
    output logic         svc_is_reset,
    output logic         svc_push,
    output logic [15:0]  svc_push_word,
    output logic [15:0]  svc_vector,
    output logic [15:0]  fr_clr_mask,
    output logic [15:0]  pend_out
);
    logic [2:0]       pin_rise;
    pend_t            raw_req, en_gate, set_vec, clr_vec, pend;
    logic             sel_any;
    logic [IDX_W-1:0] sel_idx, cur_idx;
    svc_state_e       state;
    logic             busy, cur_reset;

    intr_edge_sync #(.N(3), .SYNC_LEN(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  ({irq_pin, bus_pin, nmi_pin}),
        .rise (pin_rise)
    );

    // Collect every request source into one word before gating.
    always_comb begin
        raw_req            = raise_en ? raise_bits : '0;
        raw_req[SRC_NMI]   = raw_req[SRC_NMI]   | pin_rise[0];
        raw_req[SRC_BUS]   = raw_req[SRC_BUS]   | pin_rise[1];
        raw_req[SRC_IRQ]   = raw_req[SRC_IRQ]   | pin_rise[2];
        raw_req[SRC_ARITH] = raw_req[SRC_ARITH] | arith_err;
        raw_req[SRC_SW]    = raw_req[SRC_SW]    | sw_req;
    end

    assign en_gate = {fr_enable, {MASK_LO{1'b1}}} & LIVE_MASK;
    assign set_vec = raw_req & en_gate;

    // Retire the open source on acknowledge; reset retires everything.
    always_comb begin
        clr_vec = '0;
        if (busy && svc_ack) begin
            if (cur_reset) clr_vec = '1;
            else           clr_vec = pend_t'(1) << cur_idx;
        end
    end

    intr_pend_reg u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .pend   (pend)
    );

    intr_select u_sel (
        .pend     (pend),
        .fr_enable(fr_enable),
        .any      (sel_any),
        .sel      (sel_idx)
    );

    // Service handshake: capture at a boundary, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (boundary && sel_any) begin
                    state   <= ST_BUSY;
                    cur_idx <= sel_idx;
                end
                ST_BUSY: if (svc_ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state == ST_BUSY);
    assign cur_reset = (cur_idx == IDX_W'(SRC_RST));

    // Drive the entry information for the open service.
    always_comb begin
        svc_valid     = busy;
        svc_index     = cur_idx;
        svc_is_reset  = busy && cur_reset;
        svc_push      = busy && !cur_reset;
        svc_push_word = '0;
        svc_vector    = '0;
        fr_clr_mask   = '0;
        if (busy) begin
            svc_vector = {{(WORD_W-IDX_W-1){1'b0}}, cur_idx, 1'b0};
            if (cur_reset) fr_clr_mask = '1;
            else begin
                svc_push_word = WORD_W'(1) << cur_idx;
                if (cur_idx >= IDX_W'(MASK_LO)) fr_clr_mask = WORD_W'(1) << cur_idx;
            end
        end
    end

    assign pend_out = {{(WORD_W-INTR_N){1'b0}}, pend};

    AST_PICK_IS_SERVICEABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && boundary && sel_any) |-> (pend[sel_idx] && en_gate[sel_idx])); // R5
    AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> (svc_vector[0] == 1'b0 && svc_vector < 16'h0010)); // R6
    AST_PUSH_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        svc_push |-> $countones(svc_push_word) == 1); // R7
    AST_RESET_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        svc_is_reset |-> (!svc_push && fr_clr_mask == 16'hFFFF)); // R8
    AST_RESET_ACK_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_is_reset && svc_ack) |=> pend == $past(set_vec)); // R8
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && !svc_ack) |=> (svc_valid && $stable(svc_index))); // R10
    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && svc_ack && !svc_is_reset && !set_vec[svc_index])
        |=> !pend[$past(svc_index)]); // R10
    AST_ACK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && svc_ack) |=> !svc_valid); // R10
endmodule

// File: tb/intr_ctrl_bench.sv
module intr_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_pin = 0, bus_pin = 0, irq_pin = 0;
    logic        arith_err = 0, sw_req = 0, raise_en = 0;
    logic [7:0]  raise_bits = '0;
    logic [3:0]  fr_enable = '0;
    logic        boundary = 0, svc_ack = 0;
    logic        svc_valid, svc_is_reset, svc_push;
    logic [2:0]  svc_index;
    logic [15:0] svc_push_word, svc_vector, fr_clr_mask, pend_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10ns clk = ~clk;

    intr_ctrl u_intr_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .bus_pin(bus_pin),
        .irq_pin(irq_pin), .arith_err(arith_err), .sw_req(sw_req),
        .raise_en(raise_en), .raise_bits(raise_bits), .fr_enable(fr_enable),
        .boundary(boundary), .svc_ack(svc_ack), .svc_valid(svc_valid),
        .svc_index(svc_index), .svc_is_reset(svc_is_reset), .svc_push(svc_push),
        .svc_push_word(svc_push_word), .svc_vector(svc_vector),
        .fr_clr_mask(fr_clr_mask), .pend_out(pend_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements.
    logic [7:0] m_pend;
    logic       m_busy;
    logic [2:0] m_idx;
    logic [2:0] ms1, ms2, ms3;

    function automatic logic [3:0] ref_pick(input logic [7:0] p, input logic [3:0] en);
        logic [3:0] r = 4'b0;
        for (int i = 7; i >= 0; i--) begin
            if (p[i] && (i < 4 || en[i-4])) r = {1'b1, 3'(i)};
        end
        return r;
    endfunction

    always @(posedge clk) begin
        logic [7:0] req, gate, clr;
        logic [2:0] rise;
        logic [3:0] pk;
        if (!rst_n) begin
            m_pend <= 8'h01; m_busy <= 0; m_idx <= 0;
            ms1 <= 0; ms2 <= 0; ms3 <= 0;
        end else begin
            rise = ms2 & ~ms3;
            req  = raise_en ? raise_bits : 8'h00;
            req[1] |= rise[0]; req[2] |= rise[1]; req[7] |= rise[2];
            req[4] |= arith_err; req[5] |= sw_req;
            gate = {fr_enable[3], 1'b0, fr_enable[1], fr_enable[0], 4'b0111};
            clr  = 8'h00;
            if (m_busy && svc_ack) clr = (m_idx == 0) ? 8'hFF : (8'h01 << m_idx);
            m_pend <= (m_pend & ~clr) | (req & gate);
            pk = ref_pick(m_pend, fr_enable);
            if (m_busy && svc_ack) m_busy <= 0;
            else if (!m_busy && boundary && pk[3]) begin
                m_busy <= 1; m_idx <= pk[2:0];
            end
            ms1 <= {irq_pin, bus_pin, nmi_pin}; ms2 <= ms1; ms3 <= ms2;
        end
    end

    // Compare every output with the model in every cycle after reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 pending word", pend_out, {8'h00, m_pend});
            check("R10 valid", {15'b0, svc_valid}, {15'b0, m_busy});
            if (m_busy) begin
                check("R5 index", {13'b0, svc_index}, {13'b0, m_idx});
                check("R6 vector", svc_vector, {12'b0, m_idx, 1'b0});
                check("R7 push", {15'b0, svc_push}, {15'b0, m_idx != 0});
                check("R7 push word", svc_push_word, (m_idx == 0) ? 16'h0 : (16'h1 << m_idx));
                check("R9 clear mask", fr_clr_mask,
                      (m_idx == 0) ? 16'hFFFF : (m_idx >= 4) ? (16'h1 << m_idx) : 16'h0);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Open one service, return its index, then acknowledge it.
    task automatic serve(output logic [2:0] idx);
        boundary = 1;
        @(negedge clk);
        boundary = 0;
        idx = svc_index;
        svc_ack = 1;
        @(negedge clk);
        svc_ack = 0;
    endtask

    initial begin
        #(20ns * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [2:0] got;
        void'($urandom(32'd4711));
        cyc(3);
        rst_n = 1;
        cyc(1);
        check("R1 reset pending", pend_out, 16'h0001);
        check("R1 reset no service", {15'b0, svc_valid}, 16'h0);

        // Reset source: no push, full flag clear, drains pending word.
        boundary = 1; cyc(1); boundary = 0;
        check("R8 reset flag", {15'b0, svc_is_reset}, 16'h1);
        check("R8 reset no push", {15'b0, svc_push}, 16'h0);
        check("R6 reset vector", svc_vector, 16'h0000);
        svc_ack = 1; cyc(1); svc_ack = 0;
        check("R8 reset ack clears", pend_out, 16'h0000);

        // Synchronizer latency and single latch per level.
        nmi_pin = 1; cyc(2);
        check("R2 not yet", pend_out, 16'h0000);
        cyc(1);
        check("R2 nmi latched", pend_out, 16'h0002);
        serve(got);
        check("R2 nmi index", {13'b0, got}, 16'h1);
        cyc(4);
        check("R2 held level once", pend_out, 16'h0000);
        nmi_pin = 0;

        // Disabled maskable sources are dropped.
        fr_enable = 4'b0000;
        arith_err = 1; sw_req = 1; irq_pin = 1; cyc(1);
        arith_err = 0; sw_req = 0; cyc(4);
        check("R3 disabled dropped", pend_out, 16'h0000);
        irq_pin = 0;

        raise_en = 1; raise_bits = 8'hFE; cyc(1); raise_en = 0;
        check("R4 raise gated", pend_out, 16'h0006);
        fr_enable = 4'b1111;
        raise_en = 1; raise_bits = 8'hFE; cyc(1); raise_en = 0;
        check("R4 dead bits stay zero", pend_out, 16'h00B6);

        // Drain with source 4 disabled: order 1,2,5,7; 4 stays pending.
        fr_enable = 4'b1110;
        serve(got); check("R5 order first", {13'b0, got}, 16'h1);
        serve(got); check("R5 order second", {13'b0, got}, 16'h2);
        serve(got); check("R5 order third", {13'b0, got}, 16'h5);
        serve(got); check("R5 order fourth", {13'b0, got}, 16'h7);
        boundary = 1; cyc(2); boundary = 0;
        check("R5 disabled skipped", {15'b0, svc_valid}, 16'h0);
        check("R5 disabled kept", pend_out, 16'h0010);
        fr_enable = 4'b1111;
        serve(got); check("R9 arith index", {13'b0, got}, 16'h4);

        // Same-cycle acknowledge and new request of the same source.
        sw_req = 1; cyc(1); sw_req = 0;
        boundary = 1; cyc(1); boundary = 0;
        check("R9 sw clear mask", fr_clr_mask, 16'h0020);
        svc_ack = 1; sw_req = 1; cyc(1); svc_ack = 0; sw_req = 0;
        check("R10 valid drops", {15'b0, svc_valid}, 16'h0);
        check("R10 new request survives", pend_out, 16'h0020);
        serve(got);

        // Random phase against the model.
        for (int k = 0; k < 4000; k++) begin
            fr_enable  = 4'($urandom);
            arith_err  = ($urandom % 8) == 0;
            sw_req     = ($urandom % 8) == 0;
            raise_en   = ($urandom % 16) == 0;
            raise_bits = 8'($urandom);
            boundary   = ($urandom % 2) == 0;
            svc_ack    = svc_valid && (($urandom % 2) == 0);
            if (($urandom % 16) == 0) nmi_pin = ~nmi_pin;
            if (($urandom % 16) == 0) bus_pin = ~bus_pin;
            if (($urandom % 16) == 0) irq_pin = ~irq_pin;
            cyc(1);
        end
        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule